// File: doc/BRIEF.md
# Edge-Timestamping Capture Channel

This block records the time at which a chosen edge arrives on an asynchronous input pin. A free-running count from elsewhere in the chip is sampled whenever a qualified event occurs. Each sampled value goes into a capture register, and a capture flag is raised. Software or a neighbouring block measures period, pulse width or duty cycle by taking the difference of successive captures.

The pin is first brought into the clock domain by a two-flop synchronizer. A run-length filter then rejects glitches. The active edge is either rising or falling, chosen by a polarity input. A prescaler passes only every 1st, 2nd, 4th or 8th active edge to the capture stage. A capture made while the capture flag is still set also raises an over-capture flag, which tells the reader that a timestamp was lost. Both flags clear only when the clear strobe is pulsed.

Top module: `capture_channel`

## Requirements
- R1: After reset, `cap_value` is 0 and both `cap_flag` and `ovr_flag` are 0.
- R2: With a filter length of N, a pin level change that is present before rising clock edge k makes a capture at clock edge k+N+2, provided that change is an active edge. That capture loads the `count_in` value seen at edge k+N+2 into `cap_value`.
- R3: The active edge is selected by `pol_fall`. With `pol_fall` at 0 only rising edges capture. With `pol_fall` at 1 only falling edges capture. An edge of the other direction leaves `cap_value` and `cap_flag` unchanged.
- R4: `filt_sel` sets the filter length N: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. A new pin level is accepted only after N consecutive synchronized samples at that level. A shorter pulse makes no capture.
- R5: `psc_sel` sets the prescale ratio: 0 gives every active edge, 1 gives every 2nd, 2 gives every 4th and 3 gives every 8th. Only those edges capture.
- R6: While `enable` is 0, nothing is captured and the prescaler's edge count returns to zero. After re-enabling, a full set of edges is needed again before a capture.
- R7: Every capture sets `cap_flag`. The flag stays set until `flag_clr` is sampled high at a clock edge where no capture happens.
- R8: `ovr_flag` is set by a capture that happens while `cap_flag` is already set. `ovr_flag` is only ever set while `cap_flag` is set. A `flag_clr` pulse clears both flags.
- R9: If `flag_clr` and a capture fall on the same clock edge, the capture wins. `cap_flag` ends up 1, `ovr_flag` ends up 0, and `cap_value` takes the new count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Asynchronous input to timestamp |
| count_in | input | CW | Free-running count value to sample |
| enable | input | 1 | Channel enable; low clears the prescaler count |
| filt_sel | input | 2 | Filter length select (N = 1, 2, 4, 8) |
| pol_fall | input | 1 | 0: rising edge active, 1: falling edge active |
| psc_sel | input | 2 | Prescale select (every 1st, 2nd, 4th, 8th edge) |
| flag_clr | input | 1 | Strobe that clears both flags |
| cap_value | output | CW | Last captured count |
| cap_flag | output | 1 | Capture occurred |
| ovr_flag | output | 1 | Capture occurred while `cap_flag` was set |

## Verification
A capture lands N+2 clock edges after the edge that first samples the new pin level. The flags change at the edge after the strobe that causes them. The bench steps the count by one on every falling clock edge and changes the pin on that same falling edge. Because of this, the expected capture value is the count at the time of the pin change plus N+2. Latency checks read the flags one falling edge before and one falling edge after the due edge. The other checks wait until every pipeline stage has settled, and all sampling is done on falling edges.

// File: rtl/capture_channel.sv
module capture_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_in,
  input  logic [CW-1:0] count_in,
  input  logic          enable,
  input  logic [1:0]    filt_sel,
  input  logic          pol_fall,
  input  logic [1:0]    psc_sel,
  input  logic          flag_clr,
  output logic [CW-1:0] cap_value,
  output logic          cap_flag,
  output logic          ovr_flag
);
  localparam int RW = 3;

  logic          sync1, sync2;
  logic          lvl, lvl_q;
  logic [RW-1:0] run_cnt;
  logic [RW-1:0] ev_cnt;
  logic [RW:0]   filt_need, psc_div;
  logic          accept, edge_hit, last_ev, fire;

  assign filt_need = (RW+1)'(1) << filt_sel;
  assign psc_div   = (RW+1)'(1) << psc_sel;
  assign accept    = ({1'b0, run_cnt} + (RW+1)'(1)) >= filt_need;
  assign edge_hit  = pol_fall ? (lvl_q & ~lvl) : (lvl & ~lvl_q);
  assign last_ev   = {1'b0, ev_cnt} == (psc_div - (RW+1)'(1));
  assign fire      = enable & edge_hit & last_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl     <= 1'b0;
      run_cnt <= '0;
    end else if (sync2 == lvl) begin
      run_cnt <= '0;
    end else if (accept) begin
      lvl     <= sync2;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + RW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ev_cnt <= '0;
    else if (!enable)  ev_cnt <= '0;
    else if (edge_hit) ev_cnt <= last_ev ? '0 : ev_cnt + RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_value <= '0;
      cap_flag  <= 1'b0;
      ovr_flag  <= 1'b0;
    end else begin
      if (fire) cap_value <= count_in;
      cap_flag <= fire | (cap_flag & ~flag_clr);
      ovr_flag <= (fire & cap_flag & ~flag_clr) | (ovr_flag & ~flag_clr);
    end
  end
endmodule

module capture_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          flag_clr,
  input logic [CW-1:0] cap_value,
  input logic          cap_flag,
  input logic          ovr_flag
);
  assert_ovr_needs_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag |-> cap_flag);
  assert_ovr_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(cap_flag));
  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && !flag_clr) |=> cap_flag);
  assert_value_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_value) |-> cap_flag);
  assert_idle_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(cap_value));
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !ovr_flag);
endmodule

bind capture_channel capture_channel_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .flag_clr(flag_clr),
  .cap_value(cap_value), .cap_flag(cap_flag), .ovr_flag(ovr_flag)
);

// File: tb/test_capture_channel.sv
module test_capture_channel;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pin_in = 1'b0;
  logic [CW-1:0] count_in = '0;
  logic          enable = 1'b1;
  logic [1:0]    filt_sel = 2'd0;
  logic          pol_fall = 1'b0;
  logic [1:0]    psc_sel = 2'd0;
  logic          flag_clr = 1'b0;
  logic [CW-1:0] cap_value;
  logic          cap_flag, ovr_flag;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  capture_channel #(.CW(CW)) i_capture_channel (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .count_in(count_in),
    .enable(enable), .filt_sel(filt_sel), .pol_fall(pol_fall),
    .psc_sel(psc_sel), .flag_clr(flag_clr), .cap_value(cap_value),
    .cap_flag(cap_flag), .ovr_flag(ovr_flag)
  );

  function automatic int flen(input logic [1:0] s);
    return 1 << s;
  endfunction

  function automatic logic [CW-1:0] due_value(input logic [CW-1:0] c, input int n);
    return c + CW'(n + 2);
  endfunction

  function automatic bit is_active(input logic nv, input logic pol);
    return pol ? !nv : nv;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    count_in = count_in + 1'b1;
  endtask

  task automatic wait_n(input int k);
    for (int i = 0; i < k; i++) tick();
  endtask

  task automatic set_pin(input logic v, output logic [CW-1:0] c);
    tick();
    pin_in = v;
    c = count_in;
  endtask

  task automatic do_clear();
    tick(); flag_clr = 1'b1;
    tick(); flag_clr = 1'b0;
    tick();
  endtask

  task automatic rise_fall(output logic [CW-1:0] c);
    logic [CW-1:0] d;
    set_pin(1'b1, c); wait_n(12);
    set_pin(1'b0, d); wait_n(12);
  endtask

  initial begin
    logic [CW-1:0] c, c2, base, ev;
    int n, evm;
    bit ef, eo;
    void'($urandom(32'd24680));
    wait_n(4);
    rst_n = 1'b1;
    tick();
    chk("R1 value", cap_value, 0);
    chk("R1 flag", cap_flag, 0);
    chk("R1 ovr", ovr_flag, 0);

    // R2 latency with N=1
    n = flen(filt_sel);
    set_pin(1'b1, c);
    wait_n(n + 2);
    chk("R2 not yet", cap_flag, 0);
    tick();
    chk("R2 flag", cap_flag, 1);
    chk("R2 value", cap_value, due_value(c, n));
    do_clear();
    chk("R7 cleared", cap_flag, 0);

    // R3 falling polarity
    pol_fall = 1'b1;
    set_pin(1'b0, c); wait_n(8);
    chk("R3 fall value", cap_value, due_value(c, 1));
    do_clear();
    base = cap_value;
    set_pin(1'b1, c2); wait_n(10);
    chk("R3 rise ignored flag", cap_flag, 0);
    chk("R3 rise ignored value", cap_value, base);
    set_pin(1'b0, c); wait_n(8);
    chk("R3 fall again", cap_value, due_value(c, 1));
    pol_fall = 1'b0;
    do_clear();

    // R4 filter, N=4
    filt_sel = 2'd2; n = flen(filt_sel);
    set_pin(1'b1, c2); wait_n(2);
    set_pin(1'b0, c2); wait_n(14);
    chk("R4 glitch rejected", cap_flag, 0);
    set_pin(1'b1, c);
    wait_n(n + 2);
    chk("R4 not yet", cap_flag, 0);
    tick();
    chk("R4 flag", cap_flag, 1);
    chk("R4 value", cap_value, due_value(c, n));
    set_pin(1'b0, c2); wait_n(12);
    filt_sel = 2'd0;
    do_clear();

    // R5 prescale every 4th
    psc_sel = 2'd2;
    tick(); enable = 1'b0; tick(); enable = 1'b1;
    for (int i = 0; i < 3; i++) rise_fall(c);
    chk("R5 three edges", cap_flag, 0);
    rise_fall(c);
    chk("R5 fourth edge flag", cap_flag, 1);
    chk("R5 fourth edge value", cap_value, due_value(c, 1));
    do_clear();

    // R6 disable resets the count
    rise_fall(c); rise_fall(c);
    tick(); enable = 1'b0;
    rise_fall(c); rise_fall(c);
    chk("R6 disabled no capture", cap_flag, 0);
    enable = 1'b1;
    for (int i = 0; i < 3; i++) rise_fall(c);
    chk("R6 count restarted", cap_flag, 0);
    rise_fall(c);
    chk("R6 capture after four", cap_value, due_value(c, 1));
    psc_sel = 2'd0;
    do_clear();

    // R8 over-capture
    rise_fall(c);
    rise_fall(c2);
    chk("R8 ovr set", ovr_flag, 1);
    chk("R8 flag still set", cap_flag, 1);
    chk("R8 second value", cap_value, due_value(c2, 1));
    do_clear();
    chk("R8 ovr cleared", ovr_flag, 0);
    chk("R8 flag cleared", cap_flag, 0);

    // R9 clear coinciding with capture
    rise_fall(c);
    set_pin(1'b1, c);
    wait_n(3);
    flag_clr = 1'b1;
    tick();
    flag_clr = 1'b0;
    tick();
    chk("R9 flag kept", cap_flag, 1);
    chk("R9 ovr dropped", ovr_flag, 0);
    chk("R9 value", cap_value, due_value(c, 1));
    set_pin(1'b0, c2); wait_n(10);
    do_clear();

    // random configurations
    for (int k = 0; k < 6; k++) begin
      filt_sel = 2'($urandom % 4);
      psc_sel  = 2'($urandom % 4);
      pol_fall = 1'($urandom % 2);
      n = flen(filt_sel);
      tick(); enable = 1'b0; tick(); enable = 1'b1;
      wait_n(12);
      do_clear();
      evm = 0; ef = 0; eo = 0; ev = cap_value;
      for (int t = 0; t < 20; t++) begin
        logic nv;
        nv = ~pin_in;
        set_pin(nv, c);
        if (is_active(nv, pol_fall)) begin
          evm++;
          if (evm == (1 << psc_sel)) begin
            evm = 0;
            ev = due_value(c, n);
            if (ef) eo = 1;
            ef = 1;
          end
        end
        wait_n(n + 4 + int'($urandom % 6));
        chk("R5 random value", cap_value, ev);
        chk("R7 random flag", cap_flag, ef);
        chk("R8 random ovr", ovr_flag, eo);
      end
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule